// File: doc/BRIEF.md
# Five-Operation Integer ALU

This block is the combinational arithmetic-logic unit of a small single-cycle load/store processor. It takes two operands and a 3-bit operation code, and returns a result word and a flag that is high when that word is all zeros. The branch logic reads the flag to resolve an equality branch: it subtracts the two registers and branches when the flag is high.

One adder does all the arithmetic. Bit 2 of the operation code does two things: it makes the adder use the complement of operand B, and it supplies the carry-in of one. That one adder therefore serves addition, subtraction and the signed less-than compare. The less-than result is taken from the sign of the difference, corrected by the adder's signed overflow. It is therefore correct when the operands have opposite signs.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b010 drives the result to A plus B, modulo 2^32.
- R2: Operation code 3'b110 drives the result to A minus B, modulo 2^32. Nothing reports overflow.
- R3: Operation code 3'b000 drives the result to the bitwise AND of A and B.
- R4: Operation code 3'b001 drives the result to the bitwise OR of A and B.
- R5: Operation code 3'b111 drives the result to 1 when A is less than B as two's-complement numbers, and to 0 otherwise. The answer stays correct when A minus B overflows.
- R6: Under operation code 3'b111, result bits 31 down to 1 are always zero. Only bit 0 carries the compare outcome.
- R7: The zero flag is 1 exactly when all 32 result bits are 0, whatever the operation.
- R8: Operation codes 3'b011, 3'b100 and 3'b101 drive a result of all zeros. The zero flag is therefore 1 for these codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code; bit 2 selects the complemented B and a carry-in of one |
| res_o | output | 32 | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The zero flag is combined with every operation, and the cases that matter most are the ones where it must rise in the same evaluation as an arithmetic wrap or a compare. Examples are a subtraction of equal operands, an addition of all-ones and one, and a less-than that is false. The vector table places each of these on purpose. The random sweep adds operand pairs whose sign bits differ, which makes the subtractor overflow inside the compare. In every case the bench compares both the result and the flag against a reference model.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  logic             inv_b;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_w;
  logic             ovf;
  logic             less;

  assign inv_b = op_i[2];
  assign b_eff = inv_b ? ~b_i : b_i;
  assign sum_w = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, inv_b};
  assign ovf   = (a_i[MSB] == b_eff[MSB]) && (sum_w[MSB] != a_i[MSB]);
  assign less  = sum_w[MSB] ^ ovf;

  always_comb begin
    case (op_i)
      3'b010, 3'b110: res_o = sum_w[MSB:0];
      3'b000:         res_o = a_i & b_i;
      3'b001:         res_o = a_i | b_i;
      3'b111:         res_o = {{(WIDTH-1){1'b0}}, less};
      default:        res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;
endmodule

module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == 3'b010)
        p_add_inverse_r1: assert (res_o - b_i == a_i) else $error("R1 add");
      if (op_i == 3'b110)
        p_sub_inverse_r2: assert (res_o + b_i == a_i) else $error("R2 sub");
      if (op_i == 3'b000)
        p_and_subset_r3: assert (((res_o & ~a_i) == '0) && ((res_o & ~b_i) == '0)) else $error("R3 and");
      if (op_i == 3'b001)
        p_or_superset_r4: assert (((res_o & a_i) == a_i) && ((res_o & b_i) == b_i)) else $error("R4 or");
      if (op_i == 3'b111 && a_i == b_i)
        p_slt_equal_r5: assert (res_o == '0) else $error("R5 slt equal");
      if (op_i == 3'b111)
        p_slt_upper_r6: assert (res_o[WIDTH-1:1] == '0) else $error("R6 slt upper");
      p_zero_flag_r7: assert (zero_o == (res_o == '0)) else $error("R7 zero");
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
        p_unused_zero_r8: assert (res_o == '0 && zero_o) else $error("R8 unused");
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_o), .zero_o(zero_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [31:0] res;
  logic        zero;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alu_core u_alu_core (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .zero_o(zero));

  localparam int NV = 14;
  // {op, a, b, expected}
  localparam logic [98:0] VEC [NV] = '{
    {3'b010, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {3'b110, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    {3'b110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
    {3'b000, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0},
    {3'b001, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
    {3'b111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {3'b111, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
    {3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
    {3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
    {3'b111, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000},
    {3'b011, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_0000},
    {3'b100, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_0000},
    {3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b010: return "R1";
      3'b110: return "R2";
      3'b000: return "R3";
      3'b001: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      3'b010: return x + y;
      3'b110: return x - y;
      3'b000: return x & y;
      3'b001: return x | y;
      3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input logic [31:0] exp);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    check(req_of(o), res, exp);
    check("R7", {31'd0, zero}, {31'd0, exp == 32'd0});
    if (o == 3'b111) check("R6", {1'b0, res[31:1]}, 32'd0);
  endtask

  initial begin
    op = 3'b011; a = 32'h0; b = 32'h0;
    @(negedge clk);
    check("R8", res, 32'd0);
    check("R7", {31'd0, zero}, 32'd1);
    for (int i = 0; i < NV; i++)
      apply(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    for (int i = 0; i < 2000; i++) begin
      logic [2:0]  o;
      logic [31:0] x, y;
      o = 3'($urandom_range(0, 7));
      x = $urandom;
      y = (i % 5 == 0) ? x : $urandom;
      if (i % 7 == 0) y = {~x[31], y[30:0]};
      apply(o, x, y, ref_alu(o, x, y));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule